// File: doc/BRIEF.md
# USB Host Functional State Controller

This block holds the two-bit functional state of a USB host controller and moves it among four states: reset, resume, operational and suspend. Software sets the state through a single-cycle write strobe. A hardware reset and a software reset lead to different states. A hardware reset places the controller in the reset state and also resets the root hub, sending reset signaling toward the downstream ports. A software reset places it in suspend. The controller changes the state by itself in one case only: a resume event from a downstream port while it is suspended moves it to resume.

When the state enters operational from any other state, the block counts a fixed number of pulses on a 12 MHz tick enable, one millisecond by default. It then raises a start-of-frame enable for the frame engine and sets a sticky status flag, which software can poll to learn that frames have started. Software clears the flag by writing a one to the clear strobe. If software takes the state out of operational before the delay ends, the pending start is cancelled. A later entry starts the count again from zero.

Top module: `usbh_fstate_ctrl`

## Requirements
- R1: State codes are 2'b00 reset, 2'b01 resume, 2'b10 operational and 2'b11 suspend. A clock edge that samples `rst` high sets the state to 2'b00 and clears `sof_en_o` and `sof_flag_o`.
- R2: A `sw_reset` pulse sets the state to 2'b11 at the next edge and clears `sof_en_o` and `sof_flag_o`. It takes priority over a write that comes in the same cycle.
- R3: A write (`wr_en` high, no `sw_reset`) loads `wr_state` into the state at the next edge. Any code may be written from any state.
- R4: When `rmt_resume` is high, no write or software reset is present and the state is 2'b11, the state becomes 2'b01 at the next edge. In every other state `rmt_resume` has no effect. A write in the same cycle wins over the resume event.
- R5: Without a write or a software reset, the state holds. The only exception is the resume event of R4.
- R6: After the state enters 2'b10 from another code, `sof_en_o` rises at the edge that samples the TICKS_PER_MS-th high `tick_12m`. Only ticks sampled while the state already reads 2'b10 are counted.
- R7: Writing 2'b10 while already in 2'b10 does not restart the count. Leaving 2'b10 before the count ends cancels the pending start, and the next entry counts from zero.
- R8: `sof_en_o` is low whenever the state is not 2'b10.
- R9: `sof_flag_o` is set at the edge where `sof_en_o` rises. It stays set when `sof_en_o` falls. A `clr_sof` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R10: `roothub_rst_o` is high in the cycle after each edge that samples `rst` high. `ds_reset_strobe_o` is a one-cycle pulse after the first edge that samples `rst` low following a reset. A software reset asserts neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_reset | input | 1 | Software reset pulse |
| wr_en | input | 1 | State write strobe |
| wr_state | input | 2 | State code to write |
| rmt_resume | input | 1 | Resume signaling detected on a downstream port |
| tick_12m | input | 1 | 12 MHz tick enable |
| clr_sof | input | 1 | Write-one-to-clear strobe for the start-of-frame flag |
| state_o | output | 2 | Current functional state code |
| roothub_rst_o | output | 1 | Root hub reset request |
| ds_reset_strobe_o | output | 1 | Pulse that starts downstream reset signaling |
| sof_en_o | output | 1 | Start-of-frame generation running |
| sof_flag_o | output | 1 | Sticky start-of-frame status flag |

## Verification
On every cycle, the assertions check the following:
- the state-update rules: software reset to suspend, a write loads its code, resume only from suspend, the state holds otherwise;
- that the start-of-frame enable never runs outside operational;
- that the flag is set with the enable and then stays set;
- that the downstream strobe lasts one cycle.

The exact tick at which frames begin cannot be checked by a property. Nor can cancellation and restart of the delay, the set-over-clear case, or the relation between the reset outputs and the release of hardware reset. The bench's scenarios show these by sweeping every pair of source and target states, several tick spacings and the priority collisions.

// File: rtl/usbh_fs_pkg.sv
package usbh_fs_pkg;

  typedef enum logic [1:0] {
    HC_RESET  = 2'b00,
    HC_RESUME = 2'b01,
    HC_OPER   = 2'b10,
    HC_SUSP   = 2'b11
  } hc_state_e;

endpackage

// File: rtl/usbh_fs_state_reg.sv
module usbh_fs_state_reg
  import usbh_fs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sw_reset,
  input  logic      wr_en,
  input  logic [1:0] wr_state,
  input  logic      rmt_resume,
  output hc_state_e state_q,
  output hc_state_e state_d
);

  // Next-state selection: software reset, then write, then self move from suspend.
  always_comb begin
    state_d = state_q;
    if (sw_reset) begin
      state_d = HC_SUSP;
    end else if (wr_en) begin
      state_d = hc_state_e'(wr_state);
    end else if (state_q == HC_SUSP && rmt_resume) begin
      state_d = HC_RESUME;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HC_RESET;
    else     state_q <= state_d;
  end

  AST_SWRST_TO_SUSP: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> state_q == HC_SUSP); // R2

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sw_reset) |=> state_q == $past(wr_state)); // R3

  AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (rst)
    (!sw_reset && !wr_en && rmt_resume && state_q == HC_SUSP) |=> state_q == HC_RESUME); // R4

  AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    (!sw_reset && !wr_en && state_q != HC_SUSP) |=> $stable(state_q)); // R5

endmodule

// File: rtl/usbh_fs_sof_timer.sv
module usbh_fs_sof_timer
  import usbh_fs_pkg::*;
#(
  parameter int TICKS_PER_MS = 12000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sw_reset,
  input  logic      tick,
  input  logic      clr_sof,
  input  hc_state_e state_q,
  input  hc_state_e state_d,
  output logic      sof_en_q,
  output logic      sof_flag_q
);

  localparam int CW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;
  logic          in_oper;
  logic          stay_oper;
  logic          expire;

  assign in_oper   = (state_q == HC_OPER);
  assign stay_oper = (state_d == HC_OPER);
  assign expire    = in_oper && stay_oper && tick && !sof_en_q && (cnt_q == LAST);

  // Delay counter and enable: cleared whenever the state is about to leave operational.
  always_ff @(posedge clk) begin
    if (rst || !stay_oper) begin
      cnt_q    <= '0;
      sof_en_q <= 1'b0;
    end else if (in_oper && tick && !sof_en_q) begin
      if (cnt_q == LAST) begin
        sof_en_q <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Sticky status: set beats clear.
  always_ff @(posedge clk) begin
    if (rst || sw_reset)  sof_flag_q <= 1'b0;
    else if (expire)      sof_flag_q <= 1'b1;
    else if (clr_sof)     sof_flag_q <= 1'b0;
  end

  AST_SOF_ONLY_OPER: assert property (@(posedge clk) disable iff (rst)
    sof_en_q |-> state_q == HC_OPER); // R8

  AST_NO_SOF_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q != HC_OPER) |=> !sof_en_q); // R6

  AST_FLAG_WITH_SOF: assert property (@(posedge clk) disable iff (rst)
    $rose(sof_en_q) |-> sof_flag_q); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sof_flag_q && !clr_sof && !sw_reset) |=> sof_flag_q); // R9

endmodule

// File: rtl/usbh_fs_rst_gen.sv
module usbh_fs_rst_gen (
  input  logic clk,
  input  logic rst,
  output logic roothub_rst_q,
  output logic ds_strobe_q
);

  always_ff @(posedge clk) begin
    roothub_rst_q <= rst;
    ds_strobe_q   <= roothub_rst_q & ~rst;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ds_strobe_q |=> !ds_strobe_q); // R10

  AST_RH_RST_ONLY_HW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !roothub_rst_q); // R10

endmodule

// File: rtl/usbh_fstate_ctrl.sv
module usbh_fstate_ctrl
  import usbh_fs_pkg::*;
#(
  parameter int TICKS_PER_MS = 12000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_reset,
  input  logic       wr_en,
  input  logic [1:0] wr_state,
  input  logic       rmt_resume,
  input  logic       tick_12m,
  input  logic       clr_sof,
  output logic [1:0] state_o,
  output logic       roothub_rst_o,
  output logic       ds_reset_strobe_o,
  output logic       sof_en_o,
  output logic       sof_flag_o
);

  hc_state_e st_q;
  hc_state_e st_d;

  usbh_fs_state_reg u_state (
    .clk        (clk),
    .rst        (rst),
    .sw_reset   (sw_reset),
    .wr_en      (wr_en),
    .wr_state   (wr_state),
    .rmt_resume (rmt_resume),
    .state_q    (st_q),
    .state_d    (st_d)
  );

  usbh_fs_sof_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_sof (
    .clk        (clk),
    .rst        (rst),
    .sw_reset   (sw_reset),
    .tick       (tick_12m),
    .clr_sof    (clr_sof),
    .state_q    (st_q),
    .state_d    (st_d),
    .sof_en_q   (sof_en_o),
    .sof_flag_q (sof_flag_o)
  );

  usbh_fs_rst_gen u_rst (
    .clk           (clk),
    .rst           (rst),
    .roothub_rst_q (roothub_rst_o),
    .ds_strobe_q   (ds_reset_strobe_o)
  );

  assign state_o = st_q;

endmodule

// File: tb/usbh_fstate_ctrl_tb.sv
module usbh_fstate_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_reset = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_state = 2'b00;
  logic rmt_resume = 1'b0;
  logic tick_12m = 1'b0;
  logic clr_sof = 1'b0;
  logic [1:0] state_o;
  logic roothub_rst_o, ds_reset_strobe_o, sof_en_o, sof_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  usbh_fstate_ctrl #(.TICKS_PER_MS(T)) u_dut (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .wr_en(wr_en), .wr_state(wr_state),
    .rmt_resume(rmt_resume), .tick_12m(tick_12m), .clr_sof(clr_sof),
    .state_o(state_o), .roothub_rst_o(roothub_rst_o),
    .ds_reset_strobe_o(ds_reset_strobe_o), .sof_en_o(sof_en_o), .sof_flag_o(sof_flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] v);
    wr_en = 1'b1; wr_state = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick_12m = 1'b1;
      @(negedge clk);
      tick_12m = 1'b0;
      cyc(gap);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 / R1: hardware reset behaviour
    cyc(3);
    chk("R1 reset state", state_o, 0);
    chk("R1 sof_en in reset", sof_en_o, 0);
    chk("R1 flag in reset", sof_flag_o, 0);
    chk("R10 roothub during reset", roothub_rst_o, 1);
    chk("R10 no strobe during reset", ds_reset_strobe_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 roothub released", roothub_rst_o, 0);
    chk("R10 strobe after release", ds_reset_strobe_o, 1);
    @(negedge clk);
    chk("R10 strobe one cycle", ds_reset_strobe_o, 0);

    // R3: every source/target pair
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        wr(2'(f));
        wr(2'(t));
        chk("R3 write pair", state_o, t);
        if (t != 2) chk("R8 sof off outside oper", sof_en_o, 0);
      end
    end

    // R4 / R5: resume event from each state, then idle hold
    for (int f = 0; f < 4; f++) begin
      wr(2'(f));
      rmt_resume = 1'b1;
      @(negedge clk);
      rmt_resume = 1'b0;
      chk("R4 resume event", state_o, (f == 3) ? 1 : f);
      cyc(3);
      chk("R5 state holds", state_o, (f == 3) ? 1 : f);
    end
    // R4 write wins over resume
    wr(2'd3);
    wr_en = 1'b1; wr_state = 2'd0; rmt_resume = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rmt_resume = 1'b0;
    chk("R4 write beats resume", state_o, 0);

    // R6: delay under several tick spacings
    for (int g = 0; g < 3; g++) begin
      wr(2'd3);
      tick_12m = 1'b1;             // tick at the entry edge must not count
      wr(2'd2);
      tick_12m = 1'b0;
      for (int k = 1; k <= T; k++) begin
        ticks(1, g);
        chk("R6 sof after k ticks", sof_en_o, (k == T) ? 1 : 0);
      end
      chk("R9 flag set with sof", sof_flag_o, 1);
      clr_sof = 1'b1; @(negedge clk); clr_sof = 1'b0;
      chk("R9 flag cleared", sof_flag_o, 0);
    end

    // R9 sticky after leaving oper, then clear
    wr(2'd3); wr(2'd2); ticks(T, 1);
    wr(2'd0);
    chk("R8 sof drops on leave", sof_en_o, 0);
    chk("R9 flag sticky", sof_flag_o, 1);
    cyc(2);
    chk("R9 flag still sticky", sof_flag_o, 1);
    clr_sof = 1'b1; @(negedge clk); clr_sof = 1'b0;
    chk("R9 flag clear", sof_flag_o, 0);

    // R9 set wins over simultaneous clear
    wr(2'd2); ticks(T - 1, 0);
    tick_12m = 1'b1; clr_sof = 1'b1;
    @(negedge clk);
    tick_12m = 1'b0; clr_sof = 1'b0;
    chk("R9 set beats clear", sof_flag_o, 1);
    chk("R6 sof on collision tick", sof_en_o, 1);

    // R7 rewrite of oper does not restart
    wr(2'd1); clr_sof = 1'b1; @(negedge clk); clr_sof = 1'b0;
    wr(2'd2); ticks(T - 1, 0);
    wr(2'd2);
    ticks(1, 0);
    chk("R7 no restart on rewrite", sof_en_o, 1);

    // R7 cancel and restart from zero
    wr(2'd1); wr(2'd2); ticks(T - 1, 0);
    wr(2'd1);
    chk("R7 cancelled", sof_en_o, 0);
    wr(2'd2); ticks(T - 1, 0);
    chk("R7 restart counts from zero", sof_en_o, 0);
    ticks(1, 0);
    chk("R7 restart completes", sof_en_o, 1);

    // R2 software reset while running
    sw_reset = 1'b1; wr_en = 1'b1; wr_state = 2'd2;
    @(negedge clk);
    sw_reset = 1'b0; wr_en = 1'b0;
    chk("R2 state after sw reset", state_o, 3);
    chk("R2 sof cleared", sof_en_o, 0);
    chk("R2 flag cleared", sof_flag_o, 0);
    chk("R10 no roothub on sw reset", roothub_rst_o, 0);
    chk("R10 no strobe on sw reset", ds_reset_strobe_o, 0);

    // R1 hardware reset mid operation
    wr(2'd2); ticks(T, 0);
    rst = 1'b1; @(negedge clk);
    chk("R1 hw reset state", state_o, 0);
    chk("R1 hw reset sof", sof_en_o, 0);
    chk("R1 hw reset flag", sof_flag_o, 0);
    chk("R10 roothub on hw reset", roothub_rst_o, 1);
    rst = 1'b0; @(negedge clk);
    chk("R10 strobe after second release", ds_reset_strobe_o, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule